// File: doc/BRIEF.md
# Gated Time Base Counter

This block keeps two 64-bit time bases, a main one and an alternate one. Both advance by one on every cycle where a shared tick enable is high. An external enable pin gates them both. When the pin is low, both time bases hold their values. When it goes high again, they continue from those held values with no step. A 32-bit decrementer uses the same tick but ignores the pin. It raises an interrupt request when it counts down through zero.

Software reaches all counters through a small register port. The port has a write strobe, an address, 32-bit write data and registered 32-bit read data. Each time base is seen as a low word and a high word. Writing one word leaves the other word unchanged. The decrementer is read as a two's-complement value, so it may be negative after it expires. A separate address clears the interrupt request.

Top module: `gated_timebase`

## Requirements
- R1: After reset, both time bases read 0, the decrementer reads 0xFFFFFFFF, the interrupt request is low, and the enable is taken as low.
- R2: While the synchronized enable is high, each cycle with `tick` high adds exactly one to the main time base and to the alternate time base.
- R3: The enable pin passes through two flip-flops. Ticks that arrive three or more clock edges after a pin change use the new level. While that level is low, neither time base changes unless it is written.
- R4: When the enable returns high, both time bases continue from their held values. The first tick then adds exactly one.
- R5: The main time base uses address 0 for the low word (bits 31:0) and address 1 for the high word (bits 63:32). A write to one word replaces only that word and keeps the other. A carry out of the low word increments the high word.
- R6: The alternate time base uses address 2 for the low word and address 3 for the high word, with the same merge rule. A write to one time base never changes the other.
- R7: The decrementer uses address 4. Each tick subtracts one whether the enable is high or low. A write loads the written value.
- R8: On a tick that moves the decrementer from 0 to 0xFFFFFFFF, the interrupt request goes high. Counting then continues as a negative two's-complement value.
- R9: When a write and a tick fall in the same cycle, the written word takes the write data. The other word takes its value from the incremented count, including any carry.
- R10: Once the interrupt request is set, it stays high until a write to address 5. If a set and a clear fall in the same cycle, the set wins.
- R11: Read data is registered. It shows the word at the presented address one clock edge after the address is presented. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Count enable shared by all counters |
| tb_run_pin | input | 1 | Asynchronous, level-sensitive enable for both time bases |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| dec_irq | output | 1 | Decrementer interrupt request |

## Verification
The assertions check the cycle-level rules on every cycle: one step per gated tick, holding while the synchronized enable is low, the decrementer step, setting the interrupt on underflow, keeping the interrupt until it is cleared, and loading a written low word. Some behaviour can only be shown by the bench scenarios, because it depends on more than one cycle or on the register port. This covers the two-stage enable delay seen at the pin, resuming with no jump after a freeze, carry into the high word, a write that collides with a tick, the independence of the two time bases, and signed decrementer reads after expiry.

// File: rtl/gtb_pkg.sv
package gtb_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_MAIN_LO = 3'd0,
    RA_MAIN_HI = 3'd1,
    RA_ALT_LO  = 3'd2,
    RA_ALT_HI  = 3'd3,
    RA_DEC     = 3'd4,
    RA_IRQ_CLR = 3'd5
  } gtb_reg_e;
endpackage

// File: rtl/gtb_sync.sv
module gtb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gtb_count.sv
module gtb_count #(
  parameter int HALF_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                adv,
  input  logic                wr_lo,
  input  logic                wr_hi,
  input  logic [HALF_W-1:0]   wdata,
  output logic [2*HALF_W-1:0] cnt
);
  localparam int FULL_W = 2 * HALF_W;

  logic [FULL_W-1:0] stepped;

  always_comb begin
    stepped = adv ? cnt + FULL_W'(1) : cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else begin
      cnt[HALF_W-1:0]      <= wr_lo ? wdata : stepped[HALF_W-1:0];
      cnt[FULL_W-1:HALF_W] <= wr_hi ? wdata : stepped[FULL_W-1:HALF_W];
    end
  end
endmodule

// File: rtl/gtb_decr.sv
module gtb_decr #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         wr_val,
  input  logic         wr_clr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] val,
  output logic         irq
);
  logic underflow;

  assign underflow = tick && !wr_val && (val == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      val <= '1;
      irq <= 1'b0;
    end else begin
      if (wr_val)    val <= wdata;
      else if (tick) val <= val - W'(1);
      if (underflow)   irq <= 1'b1;
      else if (wr_clr) irq <= 1'b0;
    end
  end
endmodule

// File: rtl/gated_timebase.sv
module gated_timebase
  import gtb_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              tb_run_pin,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              dec_irq
);
  localparam int TB_W   = 2 * DATA_W;
  localparam int NUM_TB = 2;

  logic                        en_q;
  logic                        adv;
  logic [NUM_TB-1:0][TB_W-1:0] tb_cnt;
  logic [TB_W-1:0]             main_cnt;
  logic [TB_W-1:0]             alt_cnt;
  logic [DATA_W-1:0]           dec_q;
  logic [DATA_W-1:0]           rd_next;

  gtb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (tb_run_pin),
    .q   (en_q)
  );

  assign adv = tick & en_q;

  for (genvar g = 0; g < NUM_TB; g++) begin : g_tb
    logic wr_lo, wr_hi;
    assign wr_lo = reg_we && (reg_addr == 3'(2 * g));
    assign wr_hi = reg_we && (reg_addr == 3'(2 * g + 1));
    gtb_count #(.HALF_W(DATA_W)) u_cnt (
      .clk   (clk),
      .rst   (rst),
      .adv   (adv),
      .wr_lo (wr_lo),
      .wr_hi (wr_hi),
      .wdata (reg_wdata),
      .cnt   (tb_cnt[g])
    );
  end

  assign main_cnt = tb_cnt[0];
  assign alt_cnt  = tb_cnt[1];

  gtb_decr #(.W(DATA_W)) u_decr (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .wr_val (reg_we && (reg_addr == RA_DEC)),
    .wr_clr (reg_we && (reg_addr == RA_IRQ_CLR)),
    .wdata  (reg_wdata),
    .val    (dec_q),
    .irq    (dec_irq)
  );

  always_comb begin
    case (reg_addr)
      RA_MAIN_LO: rd_next = main_cnt[DATA_W-1:0];
      RA_MAIN_HI: rd_next = main_cnt[TB_W-1:DATA_W];
      RA_ALT_LO:  rd_next = alt_cnt[DATA_W-1:0];
      RA_ALT_HI:  rd_next = alt_cnt[TB_W-1:DATA_W];
      RA_DEC:     rd_next = dec_q;
      default:    rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_next;
  end
endmodule

// File: rtl/gtb_checker.sv
module gtb_checker #(
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                rst,
  input logic                tick,
  input logic                en_q,
  input logic                reg_we,
  input logic [2:0]          reg_addr,
  input logic [DATA_W-1:0]   reg_wdata,
  input logic [2*DATA_W-1:0] main_cnt,
  input logic [2*DATA_W-1:0] alt_cnt,
  input logic [DATA_W-1:0]   dec_q,
  input logic                dec_irq
);
  AST_TB_STEP: assert property (@(posedge clk) disable iff (rst)
    (tick && en_q && !reg_we) |=> (main_cnt == $past(main_cnt) + 1'b1)); // R2

  AST_TB_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (!en_q && !reg_we) |=> ($stable(main_cnt) && $stable(alt_cnt))); // R3

  AST_LO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == 3'd0) |=> (main_cnt[DATA_W-1:0] == $past(reg_wdata))); // R5

  AST_DEC_STEP: assert property (@(posedge clk) disable iff (rst)
    (tick && !reg_we) |=> (dec_q == $past(dec_q) - 1'b1)); // R7

  AST_IRQ_SET: assert property (@(posedge clk) disable iff (rst)
    (tick && !reg_we && dec_q == '0) |=> dec_irq); // R8

  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (dec_irq && !(reg_we && reg_addr == 3'd5)) |=> dec_irq); // R10
endmodule

bind gated_timebase gtb_checker #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .tick      (tick),
  .en_q      (en_q),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .main_cnt  (main_cnt),
  .alt_cnt   (alt_cnt),
  .dec_q     (dec_q),
  .dec_irq   (dec_irq)
);

// File: tb/test_gated_timebase.sv
`timescale 1ns/1ps
module test_gated_timebase;
  logic        clk = 0;
  logic        rst = 1;
  logic        tick = 0;
  logic        pin = 0;
  logic        we = 0;
  logic [2:0]  addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic        irq;

  int n_run = 0;
  int n_fail = 0;

  gated_timebase i_gated_timebase (
    .clk(clk), .rst(rst), .tick(tick), .tb_run_pin(pin),
    .reg_we(we), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rdata), .dec_irq(irq)
  );

  always #5 clk = ~clk;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk); addr = a;
    @(negedge clk); v = rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d, input logic t);
    @(negedge clk); we = 1; addr = a; wdata = d; tick = t;
    @(negedge clk); we = 0; tick = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1;
    end
    @(negedge clk); tick = 0;
  endtask

  task automatic set_pin(input logic v);
    @(negedge clk); pin = v;
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [63:0] rd64_helper(logic [31:0] hi, logic [31:0] lo);
    return {hi, lo};
  endfunction

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] lo, hi, v;
    logic [63:0] tot;
    logic [31:0] dexp;
    repeat (3) @(negedge clk);
    rst = 0;

    rd(3'd0, lo); check("R1 main lo", lo, 0);
    rd(3'd1, hi); check("R1 main hi", hi, 0);
    rd(3'd2, lo); check("R1 alt lo", lo, 0);
    rd(3'd4, v);  check("R1 dec", v, 32'hFFFF_FFFF);
    check("R1 irq", irq, 0);

    // enable low from reset: ticks must not advance time bases
    ticks(5);
    dexp = 32'hFFFF_FFFF - 5;
    rd(3'd0, lo); check("R3 frozen after reset", lo, 0);
    rd(3'd4, v);  check("R7 dec while frozen", v, dexp);

    set_pin(1);
    tot = 0;
    for (int k = 1; k <= 12; k++) begin
      ticks(k);
      tot += k;
      dexp -= k;
      rd(3'd0, lo); check("R2 main sweep", lo, tot);
      rd(3'd2, lo); check("R2 alt sweep", lo, tot);
    end
    rd(3'd4, v); check("R7 dec sweep", v, dexp);

    set_pin(0);
    ticks(10);
    dexp -= 10;
    rd(3'd0, lo); check("R3 main held", lo, tot);
    rd(3'd2, lo); check("R3 alt held", lo, tot);
    rd(3'd4, v);  check("R7 dec ignores enable", v, dexp);

    set_pin(1);
    ticks(1);
    tot += 1;
    rd(3'd0, lo); check("R4 main resume", lo, tot);
    rd(3'd2, lo); check("R4 alt resume", lo, tot);

    // half-word merge and carry
    wr(3'd0, 32'hFFFF_FFFE, 0);
    wr(3'd1, 32'h5, 0);
    rd(3'd0, lo); rd(3'd1, hi);
    check("R5 merge", rd64_helper(hi, lo), 64'h5_FFFF_FFFE);
    ticks(3);
    tot += 3;
    rd(3'd0, lo); rd(3'd1, hi);
    check("R5 carry", rd64_helper(hi, lo), 64'h6_0000_0001);

    wr(3'd3, 32'h1234, 0);
    rd(3'd2, lo); rd(3'd3, hi);
    check("R6 alt merge", rd64_helper(hi, lo), {32'h1234, tot[31:0]});
    rd(3'd1, hi); check("R6 main untouched", hi, 32'h6);

    // write colliding with a tick
    wr(3'd0, 32'hFFFF_FFFF, 0);
    wr(3'd1, 32'h5, 0);
    wr(3'd0, 32'h10, 1);
    rd(3'd0, lo); rd(3'd1, hi);
    check("R9 collision", rd64_helper(hi, lo), 64'h6_0000_0010);

    // decrementer underflow and interrupt
    wr(3'd5, 0, 0);
    wr(3'd4, 2, 0);
    ticks(2);
    rd(3'd4, v); check("R8 dec at zero", v, 0);
    check("R8 no irq at zero", irq, 0);
    ticks(1);
    check("R8 irq on underflow", irq, 1);
    ticks(2);
    rd(3'd4, v); check("R8 signed count", v, 32'hFFFF_FFFD);
    check("R10 irq held", irq, 1);
    wr(3'd5, 0, 0);
    check("R10 irq cleared", irq, 0);

    for (int s = 0; s < 8; s++) begin
      wr(3'd4, s, 0);
      ticks(s);
      check("R8 sweep pre", irq, 0);
      ticks(1);
      rd(3'd4, v); check("R8 sweep value", v, 32'hFFFF_FFFF);
      check("R8 sweep irq", irq, 1);
      wr(3'd5, 0, 0);
    end

    wr(3'd4, 0, 0);
    wr(3'd5, 0, 1);
    check("R10 set beats clear", irq, 1);
    wr(3'd5, 0, 0);
    check("R10 clear after", irq, 0);

    // read latency and unmapped address
    wr(3'd4, 32'hABCD, 0);
    rd(3'd0, lo);
    @(negedge clk); addr = 3'd4; #1;
    check("R11 old data before edge", rdata, lo);
    @(negedge clk);
    check("R11 new data after edge", rdata, 32'hABCD);
    rd(3'd7, v); check("R11 unmapped", v, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule